// File: doc/BRIEF.md
# FIFO Fill-Level Threshold Flags

The block watches the fill counts of two byte FIFOs of equal depth, a receive FIFO that software drains and a transmit FIFO that software fills. It raises one flag per FIFO when that FIFO's fill reaches a level chosen by a single shared 4-bit setting. Each flag can drive a status pin or an interrupt line.

The setting is decoded in opposite directions for the two FIFOs. As the code goes up, the receive level rises in steps of four bytes and the transmit level falls in steps of four bytes. This keeps the room left before receive overflow equal to the bytes left before transmit underflow for every code. Both flags are registered, so they update one clock after any change to a count or to the setting.

Top module: `fifo_level_flags`

## Requirements
- R1: While `rst_n` is low, both `rx_flag` and `tx_flag` are 0, whatever the counts and the setting are.
- R2: The receive level for setting s (0..15) is 4*(s+1) bytes. `rx_flag` is 1 exactly when `rx_count` is at or above that level.
- R3: The transmit level for setting s is 61 - 4*s bytes. `tx_flag` is 1 exactly when `tx_count` is at or above that level.
- R4: Each flag reflects the count and setting that were present at the previous rising clock edge. There is one register stage and no combinational path from input to flag.
- R5: With setting 13, `rx_flag` goes high when `rx_count` goes from 55 to 56 and goes low when it goes from 56 back to 55. `tx_flag` goes high when `tx_count` goes from 8 to 9 and goes low when it goes from 9 back to 8.
- R6: For every setting, the receive overflow margin (64 minus the receive level) equals the transmit underflow margin (the transmit level minus 1). For setting 13 both margins are 8 bytes.
- R7: At the ends of the count range: setting 15 with `rx_count` = 64 gives `rx_flag` = 1 and with `rx_count` = 63 gives 0. `tx_count` = 0 never sets `tx_flag`. Setting 15 with `tx_count` = 1 sets it.
- R8: A change of `thr_sel` alone, with the counts held, updates both flags on the next clock with the newly decoded levels. The two flags are computed independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_sel | input | 4 | Shared threshold setting |
| rx_count | input | 7 | Bytes held in the receive FIFO, 0..64 |
| tx_count | input | 7 | Bytes held in the transmit FIFO, 0..64 |
| rx_flag | output | 1 | Receive fill at or above its level (registered) |
| tx_flag | output | 1 | Transmit fill at or above its level (registered) |

## Verification
The assertions assume that neither count input ever exceeds the FIFO depth of 64. A count of 65 to 127 cannot occur in a real FIFO, and an assertion flags it as an illegal input. The random stimulus draws each count modulo 65, so it never leaves that range. The directed ramps stop at exactly 0 and 64, which keeps the legal extremes covered without breaking the assumption.

// File: rtl/fifo_level_pkg.sv
package fifo_level_pkg;

  localparam int unsigned LANE_RX = 0;
  localparam int unsigned LANE_TX = 1;
  localparam int unsigned NUM_LANES = 2;

  // Level for the filling direction: grows one step per code.
  function automatic int unsigned level_up(input int unsigned code,
                                           input int unsigned step);
    return step * (code + 1);
  endfunction

  // Level for the draining direction: mirror of level_up around depth+1,
  // so that the two margins match.
  function automatic int unsigned level_down(input int unsigned code,
                                             input int unsigned step,
                                             input int unsigned depth);
    return depth + 1 - level_up(code, step);
  endfunction

endpackage

// File: rtl/fifo_level_decode.sv
module fifo_level_decode #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned STEP  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] up_level,
  output logic [CNT_W-1:0] down_level
);

  always_comb begin
    up_level   = CNT_W'(fifo_level_pkg::level_up(int'(sel), STEP));
    down_level = CNT_W'(fifo_level_pkg::level_down(int'(sel), STEP, DEPTH));
  end

  // Steps of STEP keep both levels on a fixed grid.
  always_comb begin
    AST_UP_NONZERO: assert (up_level != '0);   // R2
    AST_DOWN_NONZERO: assert (down_level != '0); // R3
  end

endmodule

// File: rtl/fifo_level_cmp.sv
module fifo_level_cmp #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] level,
  output logic             flag_q
);

  logic reached;
  assign reached = (count >= level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= reached;
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (flag_q == ($past(count) >= $past(level)))); // R4

  AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(count) >= $past(level))); // R4

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned STEP  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] thr_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  output logic             rx_flag,
  output logic             tx_flag
);

  import fifo_level_pkg::*;

  logic [CNT_W-1:0] rx_level;
  logic [CNT_W-1:0] tx_level;
  logic [CNT_W-1:0] lane_count [NUM_LANES];
  logic [CNT_W-1:0] lane_level [NUM_LANES];
  logic             lane_flag  [NUM_LANES];

  fifo_level_decode #(.SEL_W(SEL_W), .DEPTH(DEPTH), .STEP(STEP)) u_decode (
    .sel        (thr_sel),
    .up_level   (rx_level),
    .down_level (tx_level)
  );

  assign lane_count[LANE_RX] = rx_count;
  assign lane_count[LANE_TX] = tx_count;
  assign lane_level[LANE_RX] = rx_level;
  assign lane_level[LANE_TX] = tx_level;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    fifo_level_cmp #(.DEPTH(DEPTH)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (lane_count[g]),
      .level  (lane_level[g]),
      .flag_q (lane_flag[g])
    );
  end

  assign rx_flag = lane_flag[LANE_RX];
  assign tx_flag = lane_flag[LANE_TX];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rx_flag && !tx_flag)); // R1

  AST_MARGIN_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(DEPTH) - rx_level) == (tx_level - CNT_W'(1))); // R6

  AST_RX_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CNT_W'(DEPTH)) |=> rx_flag); // R2

  AST_TX_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |=> !tx_flag); // R3

endmodule

// File: tb/fifo_level_flags_bench.sv
`timescale 1ns/1ps
module fifo_level_flags_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] thr_sel = '0;
  logic [6:0] rx_count = '0;
  logic [6:0] tx_count = '0;
  logic       rx_flag, tx_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fifo_level_flags u_fifo_level_flags (
    .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_flag(rx_flag), .tx_flag(tx_flag)
  );

  // Bench model: receive needs count/4 > s, transmit needs count + 4s >= 61.
  function automatic bit exp_rx(int s, int c);
    return (c / 4) > s;
  endfunction
  function automatic bit exp_tx(int s, int c);
    return (c + 4 * s) >= 61;
  endfunction

  task automatic chk(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, check at the next falling edge.
  task automatic apply(int s, int r, int t, string req);
    @(negedge clk);
    thr_sel = 4'(s); rx_count = 7'(r); tx_count = 7'(t);
    @(negedge clk);
    chk(req, $sformatf("rx s=%0d c=%0d", s, r), rx_flag, exp_rx(s, r));
    chk(req, $sformatf("tx s=%0d c=%0d", s, t), tx_flag, exp_tx(s, t));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset holds flags low even with full counts
    thr_sel = 4'd0; rx_count = 7'd64; tx_count = 7'd64;
    repeat (3) @(negedge clk);
    chk("R1", "rx in reset", rx_flag, 1'b0);
    chk("R1", "tx in reset", tx_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", "rx after release", rx_flag, 1'b1);
    chk("R4", "tx after release", tx_flag, 1'b1);

    // R2 / R3: every setting at its level and one below
    for (int s = 0; s < 16; s++) begin
      apply(s, 4 * s + 4, 61 - 4 * s, "R2");
      apply(s, 4 * s + 3, 60 - 4 * s, "R3");
    end

    // R5: ramp with setting 13, edges at 56/55 and 9/8
    for (int c = 53; c <= 57; c++) apply(13, c, c - 47, "R5");
    for (int c = 56; c >= 53; c--) apply(13, c, c - 47, "R5");

    // R6: margins equal; rx flag at 64-m, tx flag at m+1
    for (int s = 0; s < 16; s++) begin
      int m = 60 - 4 * s;
      apply(s, 64 - m, m + 1, "R6");
      apply(s, 63 - m, m, "R6");
    end

    // R7: ends of range
    apply(15, 64, 1, "R7");
    apply(15, 63, 0, "R7");
    for (int s = 0; s < 16; s++) apply(s, 0, 0, "R7");

    // R8: setting-only changes with counts held
    apply(0, 20, 40, "R8");
    apply(5, 20, 40, "R8");
    apply(4, 20, 40, "R8");
    apply(6, 20, 40, "R8");

    // R4: random mix, one register stage
    for (int i = 0; i < 3000; i++)
      apply(int'($urandom % 16), int'($urandom % 65), int'($urandom % 65), "R4");

    // R1: asserting reset mid-run clears flags
    @(negedge clk); thr_sel = 4'd0; rx_count = 7'd64; tx_count = 7'd64;
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1", "rx async clear", rx_flag, 1'b0);
    chk("R1", "tx async clear", tx_flag, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule